// File: doc/BRIEF.md
# Four-Channel Compare System Timer

This block is a timebase for a processor subsystem. It holds a free-running counter twice the bus word wide. The counter advances by one in each clock cycle in which the external tick-enable input is high. The tick source runs at about 1 MHz and is generated outside the block. The counter cannot be loaded, stopped or reloaded; only reset clears it.

Four compare channels sit beside the counter. Each holds a value one word wide, which is matched against the low word of the count only. A match latches a pending flag for that channel, and the flag drives that channel's interrupt line as a level. Software dismisses a flag by writing a one to its bit in the shared status word.

All registers sit on a single-cycle, word-indexed register port. Reads are combinational. The two counter words are read live with no snapshot. Software that needs a consistent full count reads high, low, then high again, and retries if the two high reads differ.

Top module: `sys_tick_timer`

## Requirements
- R1: After reset the counter is zero. It rises by exactly one at each clock edge where `tick_en` is high, and keeps its value at every other edge.
- R2: When the low word wraps from all-ones to zero on a tick, the high word rises by one at the same edge. Both words are read live, with no latch between the two reads.
- R3: Register index selects the register. Index 0 is status, 1 is the counter low word, 2 is the counter high word, and 3, 4, 5 and 6 are compare channels 0 to 3. A compare channel reads back the last value written to it.
- R4: Status bit n becomes 1 at the clock edge where a tick makes the counter low word equal to compare channel n. A value already equal with no tick does not set it.
- R5: A status bit, once set, stays set until software writes index 0 with a 1 in that bit position. Writing 0 to a status bit has no effect.
- R6: When a match sets bit n in the same cycle that a write clears bit n, the bit ends up set.
- R7: Output `irq[n]` always equals status bit n.
- R8: Writes to indices 1 and 2 change neither counter word.
- R9: Reset clears the counter, all four compare values and all status bits.
- R10: Index 7 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable, one pulse per tick |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 3 | Word index of the register accessed |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Read data for `reg_idx` (combinational) |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
A channel comparator that looks at the wrong counter value shows up as a status bit and irq line that rise one tick early or late. This is visible on the very next read of index 0, so compare values are placed a few ticks ahead of the count. A missing carry path or a latched read shows up at the ports only when the low word wraps, so the bench runs with a narrow word and drives the count across that boundary. An inverted set/clear priority shows up only in the single cycle where a tick match and a clear write coincide, and the bench produces that cycle on purpose.

// File: rtl/st_pkg.sv
package st_pkg;

    localparam int NUM_CH = 4;
    localparam int IDX_W  = 3;

    typedef enum logic [IDX_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_CNT_LO = 3'd1,
        SEL_CNT_HI = 3'd2,
        SEL_CMP0   = 3'd3,
        SEL_CMP1   = 3'd4,
        SEL_CMP2   = 3'd5,
        SEL_CMP3   = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     wr;
        reg_sel_e sel;
    } reg_req_t;

    function automatic reg_sel_e decode_idx(logic [IDX_W-1:0] idx);
        return reg_sel_e'(idx);
    endfunction

    function automatic reg_sel_e cmp_sel(int ch);
        return reg_sel_e'(IDX_W'(int'(SEL_CMP0) + ch));
    endfunction

endpackage

// File: rtl/st_decode.sv
module st_decode
    import st_pkg::*;
(
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    output reg_req_t          req,
    output logic              status_we,
    output logic [NUM_CH-1:0] cmp_we
);

    always_comb begin
        req.wr    = wr_en;
        req.sel   = decode_idx(reg_idx);
        status_we = req.wr && (req.sel == SEL_STATUS);
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_we
        assign cmp_we[ch] = req.wr && (req.sel == cmp_sel(ch));
    end

endmodule

// File: rtl/st_counter.sv
module st_counter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    output logic [WORD_W-1:0] cnt_lo,
    output logic [WORD_W-1:0] cnt_hi,
    output logic [WORD_W-1:0] lo_next
);

    localparam int CNT_W = 2 * WORD_W;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            cnt_q <= cnt_inc;
        end
    end

    assign cnt_lo  = cnt_q[WORD_W-1:0];
    assign cnt_hi  = cnt_q[CNT_W-1:WORD_W];
    assign lo_next = cnt_inc[WORD_W-1:0];

    assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + CNT_W'(1)));

    assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable({cnt_hi, cnt_lo}));

    assert_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (tick_en && (cnt_lo == {WORD_W{1'b1}})) |=> (cnt_lo == '0 && cnt_hi == $past(cnt_hi) + WORD_W'(1)));

endmodule

// File: rtl/st_channel.sv
module st_channel #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_we,
    input  logic [WORD_W-1:0] wdata,
    input  logic              tick_en,
    input  logic [WORD_W-1:0] lo_next,
    input  logic              clr,
    output logic [WORD_W-1:0] cmp_q,
    output logic              flag_q
);

    logic hit;

    assign hit = tick_en && (lo_next == cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else if (cmp_we) begin
            cmp_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= hit | (flag_q & ~clr);
        end
    end

    assert_match_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (tick_en && lo_next == cmp_q) |=> flag_q);

    assert_no_spurious_R4: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !(tick_en && lo_next == cmp_q)) |=> !flag_q);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    assert_cmp_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !cmp_we |=> $stable(cmp_q));

endmodule

// File: rtl/st_read_mux.sv
module st_read_mux
    import st_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  reg_sel_e                       sel,
    input  logic [NUM_CH-1:0]              status,
    input  logic [WORD_W-1:0]              cnt_lo,
    input  logic [WORD_W-1:0]              cnt_hi,
    input  logic [NUM_CH-1:0][WORD_W-1:0]  cmp,
    output logic [WORD_W-1:0]              rdata
);

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_STATUS: rdata[NUM_CH-1:0] = status;
            SEL_CNT_LO: rdata = cnt_lo;
            SEL_CNT_HI: rdata = cnt_hi;
            SEL_NONE:   rdata = '0;
            default: begin
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    if (sel == cmp_sel(ch)) rdata = cmp[ch];
                end
            end
        endcase
    end

endmodule

// File: rtl/sys_tick_timer.sv
module sys_tick_timer
    import st_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [2:0]        reg_idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic [NUM_CH-1:0] irq
);

    reg_req_t                       req;
    logic                           status_we;
    logic [NUM_CH-1:0]              cmp_we;
    logic [WORD_W-1:0]              cnt_lo;
    logic [WORD_W-1:0]              cnt_hi;
    logic [WORD_W-1:0]              lo_next;
    logic [NUM_CH-1:0]              flags;
    logic [NUM_CH-1:0][WORD_W-1:0]  cmp_vals;

    st_decode u_decode (
        .wr_en     (wr_en),
        .reg_idx   (reg_idx),
        .req       (req),
        .status_we (status_we),
        .cmp_we    (cmp_we)
    );

    st_counter #(.WORD_W(WORD_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi),
        .lo_next (lo_next)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        st_channel #(.WORD_W(WORD_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .cmp_we  (cmp_we[ch]),
            .wdata   (wdata),
            .tick_en (tick_en),
            .lo_next (lo_next),
            .clr     (status_we & wdata[ch]),
            .cmp_q   (cmp_vals[ch]),
            .flag_q  (flags[ch])
        );
    end

    st_read_mux #(.WORD_W(WORD_W)) u_rmux (
        .sel    (req.sel),
        .status (flags),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .cmp    (cmp_vals),
        .rdata  (rdata)
    );

    assign irq = flags;

    assert_irq_read_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == 3'd0) |-> (rdata[NUM_CH-1:0] == irq));

    assert_irq_rise_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (irq == '0 && !tick_en) |=> (irq == '0));

    assert_ro_counter_R8: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && wr_en && (reg_idx == 3'd1 || reg_idx == 3'd2)) |=> $stable({cnt_hi, cnt_lo}));

    assert_none_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == 3'd7) |-> (rdata == '0));

endmodule

// File: tb/sys_tick_timer_tb.sv
module sys_tick_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 10;
    localparam int NCH        = 4;
    localparam int WDOG       = 20000;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;

    typedef struct packed {
        logic [1:0]   op;
        logic [2:0]   idx;
        logic [W-1:0] val;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TABLE [NV] = '{
        '{OP_RD, 3'd1, 10'd0},     // R9 low
        '{OP_RD, 3'd2, 10'd0},     // R9 high
        '{OP_RD, 3'd0, 10'd0},     // R9 status
        '{OP_RD, 3'd3, 10'd0},     // R9 compare
        '{OP_WR, 3'd3, 10'd5},
        '{OP_WR, 3'd4, 10'd7},
        '{OP_WR, 3'd5, 10'd7},
        '{OP_WR, 3'd6, 10'd3},
        '{OP_RD, 3'd3, 10'd5},     // R3
        '{OP_RD, 3'd6, 10'd3},     // R3
        '{OP_TK, 3'd0, 10'd3},
        '{OP_RD, 3'd1, 10'd3},     // R1
        '{OP_RD, 3'd0, 10'd8},     // R4 ch3
        '{OP_TK, 3'd0, 10'd2},
        '{OP_RD, 3'd0, 10'd9},     // R4 ch0
        '{OP_WR, 3'd0, 10'd0},
        '{OP_RD, 3'd0, 10'd9},     // R5 zero write
        '{OP_WR, 3'd0, 10'd8},
        '{OP_RD, 3'd0, 10'd1},     // R5 clear
        '{OP_WR, 3'd1, 10'h3FF},
        '{OP_WR, 3'd2, 10'h155},
        '{OP_RD, 3'd1, 10'd5},     // R8
        '{OP_RD, 3'd2, 10'd0},     // R8
        '{OP_TK, 3'd0, 10'd2},
        '{OP_RD, 3'd0, 10'd7},     // R4 ch1 ch2
        '{OP_WR, 3'd0, 10'd7},
        '{OP_RD, 3'd0, 10'd0},     // R5
        '{OP_WR, 3'd7, 10'h2AA},
        '{OP_RD, 3'd7, 10'd0},     // R10
        '{OP_RD, 3'd4, 10'd7}      // R10 no side effect
    };

    logic           clk;
    logic           rst;
    logic           tick_en;
    logic           wr_en;
    logic [2:0]     reg_idx;
    logic [W-1:0]   wdata;
    logic [W-1:0]   rdata;
    logic [NCH-1:0] irq;

    int  n_checks;
    int  n_fail;
    bit  done;

    sys_tick_timer #(.WORD_W(W)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .reg_idx (reg_idx),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] idx, input logic [W-1:0] d);
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b1; reg_idx = idx; wdata = d;
    endtask

    task automatic do_read(input string req, input logic [2:0] idx, input logic [W-1:0] exp);
        @(negedge clk);
        tick_en = 1'b0; wr_en = 1'b0; reg_idx = idx; wdata = '0;
        #1;
        check(req, rdata, exp);
        if (idx == 3'd0) check({req, " irq (R7)"}, W'(irq), exp);
    endtask

    task automatic do_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1; wr_en = 1'b0; reg_idx = 3'd7; wdata = '0;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        n_checks = 0; n_fail = 0; done = 1'b0;
        rst = 1'b1; tick_en = 1'b0; wr_en = 1'b0; reg_idx = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // vector table
        for (int i = 0; i < NV; i++) begin
            case (TABLE[i].op)
                OP_WR:   do_write(TABLE[i].idx, TABLE[i].val);
                OP_RD:   do_read($sformatf("table[%0d] R1..R10", i), TABLE[i].idx, TABLE[i].val);
                default: do_ticks(int'(TABLE[i].val));
            endcase
        end

        // R2: carry from low word into high word (low is 7 here)
        do_ticks(1016);
        do_read("R2 low before wrap", 3'd1, 10'h3FF);
        do_read("R2 high before wrap", 3'd2, 10'd0);
        do_ticks(1);
        do_read("R2 low after wrap", 3'd1, 10'd0);
        do_read("R2 high after wrap", 3'd2, 10'd1);
        do_read("R4 no match across wrap", 3'd0, 10'd0);

        // R6: match and clear in the same cycle
        do_write(3'd3, 10'd2);
        do_ticks(1);
        @(negedge clk);
        tick_en = 1'b1; wr_en = 1'b1; reg_idx = 3'd0; wdata = 10'd1;
        do_read("R6 set wins over clear", 3'd0, 10'd1);

        // R1: no tick, no change
        do_read("R1 low before idle", 3'd1, 10'd2);
        repeat (5) @(negedge clk);
        do_read("R1 low after idle", 3'd1, 10'd2);

        // R9: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do_read("R9 low after reset", 3'd1, 10'd0);
        do_read("R9 high after reset", 3'd2, 10'd0);
        do_read("R9 status after reset", 3'd0, 10'd0);
        do_read("R9 compare0 after reset", 3'd3, 10'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule